// File: doc/BRIEF.md
# Continuous Array Read Address Generator

This block sits behind the byte deserializer of a serial flash front end. It watches the command bytes that arrive while chip select is held low, recognises the four array-read commands, and captures the three address bytes that follow. Each command has its own count of padding bytes after the address, and the block tracks them. It then presents the page number and byte offset for each data byte that the host clocks out.

The array has 2^PAGE_W pages. Each page holds either 528 bytes or 512 bytes, chosen by a mode input that is sampled with the command byte. The 24-bit address is split into page and offset fields according to that mode. The streaming commands run through the whole array: they step from the last byte of a page to the next page, and from the last page back to page 0, with no stall cycle. The single-page command wraps within its own page. Raising chip select ends the read at once, and the next byte after chip select falls again is taken as a new command.

Top module: `car_addr_gen`

## Requirements
- R1: Out of reset, `data_valid_o` and `dummy_o` are 0 and `page_o` and `offset_o` are 0.
- R2: The first strobed byte after chip select falls is the command. 03h, 0Bh and E8h select streaming read and D2h selects single-page read. Any other value is ignored until chip select rises: `data_valid_o` and `dummy_o` stay 0.
- R3: Three address bytes follow the command, most significant byte first. The number of padding bytes after them is 0 for 03h, 1 for 0Bh, 4 for E8h and 4 for D2h. `dummy_o` is high from the cycle after the last address strobe until the cycle after the last padding strobe. `data_valid_o` rises in that same cycle, or in the cycle after the last address strobe when the command has no padding.
- R4: In 528-byte mode the page is address bits 22:10 and the offset is bits 9:0. Bit 23 is ignored.
- R5: In 512-byte mode the page is address bits 21:9 and the offset is bits 8:0. Bits 23:22 are ignored.
- R6: In 528-byte mode, an offset field of 528 or more is loaded as 527.
- R7: During the data phase, each strobe advances the address by one byte in the following cycle. Without a strobe the address holds.
- R8: For a streaming read, a strobe on the last byte of a page (527 or 511) moves to offset 0 of the next page in the next cycle.
- R9: For a streaming read, the last byte of page 2^PAGE_W-1 is followed by page 0, offset 0.
- R10: For a single-page read (D2h), the last byte of the page is followed by offset 0 of the same page.
- R11: The cycle after chip select is high, `data_valid_o` and `dummy_o` are 0. Any partly received command is dropped.
- R12: The page-size mode is taken from `page528_i` at the command byte. Later changes during the same access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| byte_valid_i | input | 1 | One-cycle strobe per received or transmitted byte |
| byte_i | input | 8 | Received byte, valid with the strobe |
| page528_i | input | 1 | 1 selects 528-byte pages, 0 selects 512-byte pages |
| page_o | output | 13 | Current page number |
| offset_o | output | 10 | Current byte offset within the page |
| data_valid_o | output | 1 | Data phase: the address is that of the next output byte |
| dummy_o | output | 1 | Padding bytes are being consumed |

## Verification
The properties assume that `byte_valid_i` is a single-cycle pulse. They also assume that a chip select change and a strobe never fall in the same cycle, so that each step of the address can be attributed to exactly one byte. The stimulus drives every input at the falling clock edge. It holds the strobe for exactly one cycle and always spends at least one idle cycle before and after a chip select change. Page crossings, the array wrap, the single-page wrap and offset clamping are reached by starting each read close to the edge under test.

// File: rtl/car_pkg.sv
package car_pkg;
  localparam int DUMMY_W = 3;

  localparam logic [7:0] OP_RD_SLOW   = 8'h03;
  localparam logic [7:0] OP_RD_FAST   = 8'h0B;
  localparam logic [7:0] OP_RD_LEGACY = 8'hE8;
  localparam logic [7:0] OP_RD_PAGE   = 8'hD2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } seq_state_e;

  typedef struct packed {
    logic               valid;
    logic               same_page;
    logic [DUMMY_W-1:0] dummies;
  } rd_cmd_t;
endpackage

// File: rtl/car_cmd_decode.sv
module car_cmd_decode
  import car_pkg::*;
#(
  parameter int DUMMY_SLOW   = 0,
  parameter int DUMMY_FAST   = 1,
  parameter int DUMMY_LEGACY = 4,
  parameter int DUMMY_PAGE   = 4
) (
  input  logic [7:0] opcode_i,
  output rd_cmd_t    cmd_o
);
  always_comb begin
    cmd_o = '0;
    unique case (opcode_i)
      OP_RD_SLOW: begin
        cmd_o.valid   = 1'b1;
        cmd_o.dummies = DUMMY_W'(DUMMY_SLOW);
      end
      OP_RD_FAST: begin
        cmd_o.valid   = 1'b1;
        cmd_o.dummies = DUMMY_W'(DUMMY_FAST);
      end
      OP_RD_LEGACY: begin
        cmd_o.valid   = 1'b1;
        cmd_o.dummies = DUMMY_W'(DUMMY_LEGACY);
      end
      OP_RD_PAGE: begin
        cmd_o.valid     = 1'b1;
        cmd_o.same_page = 1'b1;
        cmd_o.dummies   = DUMMY_W'(DUMMY_PAGE);
      end
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/car_seq_ctrl.sv
module car_seq_ctrl
  import car_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       strobe_i,
  input  rd_cmd_t    cmd_i,
  input  logic       page528_i,
  output seq_state_e state_o,
  output logic       shift_o,
  output logic       load_o,
  output logic       step_o,
  output logic       mode528_o,
  output logic       same_page_o
);
  localparam int ABYTE_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ABYTE_W-1:0] ABYTE_LAST = ABYTE_W'(ADDR_BYTES - 1);

  seq_state_e         state_q;
  rd_cmd_t            cmd_q;
  logic               mode_q;
  logic [ABYTE_W-1:0] abyte_q;
  logic [DUMMY_W-1:0] dcnt_q;
  logic               take;

  assign take = strobe_i && !cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      mode_q  <= 1'b0;
      abyte_q <= '0;
      dcnt_q  <= '0;
    end else if (cs_ni) begin
      state_q <= ST_IDLE;
      abyte_q <= '0;
      dcnt_q  <= '0;
    end else if (take) begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_i.valid) begin
            state_q <= ST_ADDR;
            cmd_q   <= cmd_i;
            mode_q  <= page528_i;
            abyte_q <= '0;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_ADDR: begin
          if (abyte_q == ABYTE_LAST) begin
            state_q <= (cmd_q.dummies == '0) ? ST_DATA : ST_DUMMY;
            dcnt_q  <= cmd_q.dummies;
          end else begin
            abyte_q <= abyte_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          if (dcnt_q == DUMMY_W'(1)) state_q <= ST_DATA;
          dcnt_q <= dcnt_q - 1'b1;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign state_o     = state_q;
  assign shift_o     = take && (state_q == ST_ADDR) && (abyte_q != ABYTE_LAST);
  assign load_o      = take && (state_q == ST_ADDR) && (abyte_q == ABYTE_LAST);
  assign step_o      = take && (state_q == ST_DATA);
  assign mode528_o   = mode_q;
  assign same_page_o = cmd_q.same_page;
endmodule

// File: rtl/car_addr_split.sv
module car_addr_split #(
  parameter int PAGE_W     = 13,
  parameter int BIG_BYTES  = 528,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [7:0]        byte_i,
  input  logic              mode528_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [$clog2(BIG_BYTES)-1:0] off_o
);
  localparam int ADDR_W  = ADDR_BYTES * 8;
  localparam int HI_W    = ADDR_W - 8;
  localparam int OFF_W   = $clog2(BIG_BYTES);
  localparam int SOFF_W  = OFF_W - 1;
  localparam logic [OFF_W-1:0] BIG_LAST = OFF_W'(BIG_BYTES - 1);

  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] full;
  logic [OFF_W-1:0]  off_big;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (shift_i) hi_q <= {hi_q[HI_W-9:0], byte_i};
  end

  assign full    = {hi_q, byte_i};
  assign off_big = full[OFF_W-1:0];

  always_comb begin
    if (mode528_i) begin
      page_o = full[OFF_W +: PAGE_W];
      off_o  = (off_big > BIG_LAST) ? BIG_LAST : off_big;
    end else begin
      page_o = full[SOFF_W +: PAGE_W];
      off_o  = {1'b0, full[SOFF_W-1:0]};
    end
  end
endmodule

// File: rtl/car_addr_counter.sv
module car_addr_counter #(
  parameter int PAGE_W    = 13,
  parameter int BIG_BYTES = 528
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  input  logic [$clog2(BIG_BYTES)-1:0] load_off_i,
  input  logic              step_i,
  input  logic              mode528_i,
  input  logic              same_page_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [$clog2(BIG_BYTES)-1:0] off_o
);
  localparam int OFF_W = $clog2(BIG_BYTES);
  localparam logic [OFF_W-1:0] BIG_LAST   = OFF_W'(BIG_BYTES - 1);
  localparam logic [OFF_W-1:0] SMALL_LAST = OFF_W'((1 << (OFF_W - 1)) - 1);

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  last;
  logic              at_end;

  assign last   = mode528_i ? BIG_LAST : SMALL_LAST;
  assign at_end = (off_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= load_page_i;
      off_q  <= load_off_i;
    end else if (step_i) begin
      if (at_end) begin
        off_q <= '0;
        if (!same_page_i) page_q <= page_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign off_o  = off_q;
endmodule

// File: rtl/car_addr_gen.sv
module car_addr_gen
  import car_pkg::*;
#(
  parameter int PAGE_W     = 13,
  parameter int BIG_BYTES  = 528,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         byte_valid_i,
  input  logic [7:0]                   byte_i,
  input  logic                         page528_i,
  output logic [PAGE_W-1:0]            page_o,
  output logic [$clog2(BIG_BYTES)-1:0] offset_o,
  output logic                         data_valid_o,
  output logic                         dummy_o
);
  localparam int OFF_W = $clog2(BIG_BYTES);

  rd_cmd_t           cmd;
  seq_state_e        state;
  logic              shift, load, step;
  logic              mode_q, same_page_q;
  logic [PAGE_W-1:0] split_page;
  logic [OFF_W-1:0]  split_off;

  car_cmd_decode u_dec (
    .opcode_i (byte_i),
    .cmd_o    (cmd)
  );

  car_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .strobe_i    (byte_valid_i),
    .cmd_i       (cmd),
    .page528_i   (page528_i),
    .state_o     (state),
    .shift_o     (shift),
    .load_o      (load),
    .step_o      (step),
    .mode528_o   (mode_q),
    .same_page_o (same_page_q)
  );

  car_addr_split #(
    .PAGE_W(PAGE_W), .BIG_BYTES(BIG_BYTES), .ADDR_BYTES(ADDR_BYTES)
  ) u_split (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .byte_i    (byte_i),
    .mode528_i (mode_q),
    .page_o    (split_page),
    .off_o     (split_off)
  );

  car_addr_counter #(.PAGE_W(PAGE_W), .BIG_BYTES(BIG_BYTES)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_page_i (split_page),
    .load_off_i  (split_off),
    .step_i      (step),
    .mode528_i   (mode_q),
    .same_page_i (same_page_q),
    .page_o      (page_o),
    .off_o       (offset_o)
  );

  assign data_valid_o = (state == ST_DATA);
  assign dummy_o      = (state == ST_DUMMY);
endmodule

// File: rtl/car_addr_gen_chk.sv
module car_addr_gen_chk #(
  parameter int PAGE_W    = 13,
  parameter int BIG_BYTES = 528
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cs_ni,
  input logic                         byte_valid_i,
  input logic [PAGE_W-1:0]            page_o,
  input logic [$clog2(BIG_BYTES)-1:0] offset_o,
  input logic                         data_valid_o,
  input logic                         dummy_o,
  input logic                         mode_i,
  input logic                         same_page_i
);
  localparam int OFF_W = $clog2(BIG_BYTES);
  logic [OFF_W-1:0] last;
  assign last = mode_i ? OFF_W'(BIG_BYTES - 1) : OFF_W'((1 << (OFF_W - 1)) - 1);

  a_r11_cs_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!data_valid_o && !dummy_o));

  a_r3_phase_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_valid_o && dummy_o));

  a_r3_dummy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dummy_o && !byte_valid_i && !cs_ni) |=> dummy_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !byte_valid_i) |=> ($stable(page_o) && $stable(offset_o)));

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && byte_valid_i && !cs_ni && offset_o < last)
      |=> (offset_o == OFF_W'($past(offset_o) + 1) && $stable(page_o)));

  a_r8_next_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && byte_valid_i && !cs_ni && offset_o == last && !same_page_i)
      |=> (offset_o == '0 && page_o == PAGE_W'($past(page_o) + 1)));

  a_r10_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && byte_valid_i && !cs_ni && offset_o == last && same_page_i)
      |=> (offset_o == '0 && $stable(page_o)));

  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (offset_o <= last));
endmodule

bind car_addr_gen car_addr_gen_chk #(.PAGE_W(PAGE_W), .BIG_BYTES(BIG_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .byte_valid_i (byte_valid_i),
  .page_o       (page_o),
  .offset_o     (offset_o),
  .data_valid_o (data_valid_o),
  .dummy_o      (dummy_o),
  .mode_i       (mode_q),
  .same_page_i  (same_page_q)
);

// File: tb/car_addr_gen_test.sv
module car_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        bv = 1'b0;
  logic [7:0]  bd = '0;
  logic        m528 = 1'b1;
  logic [12:0] page;
  logic [9:0]  off;
  logic        dv, dm;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  car_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .byte_valid_i(bv), .byte_i(bd),
    .page528_i(m528), .page_o(page), .offset_o(off), .data_valid_o(dv), .dummy_o(dm)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] a528(input int p, input int o);
    return 24'((p << 10) | o);
  endfunction
  function automatic logic [23:0] a512(input int p, input int o);
    return 24'((p << 9) | o);
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); bv = 1'b1; bd = b;
    @(negedge clk); bv = 1'b0;
  endtask

  task automatic start(input logic [7:0] op, input logic [23:0] a, input logic mode);
    @(negedge clk); cs_n = 1'b0; m528 = mode;
    send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic stop();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "valid", int'(dv), 0);
    check("R1", "dummy", int'(dm), 0);
    check("R1", "page", int'(page), 0);
    check("R1", "offset", int'(off), 0);
  endtask

  task automatic t_slow_528();
    start(8'h03, a528(5, 3) | 24'h800000, 1'b1);
    check("R3", "03h no padding valid", int'(dv), 1);
    check("R3", "03h no padding dummy", int'(dm), 0);
    check("R4", "page", int'(page), 5);
    check("R4", "offset", int'(off), 3);
    repeat (3) send(8'h00);
    check("R7", "offset after 3 strobes", int'(off), 6);
    repeat (5) @(negedge clk);
    check("R7", "offset holds", int'(off), 6);
    stop();
    check("R11", "valid after cs high", int'(dv), 0);
  endtask

  task automatic t_fast_512();
    start(8'h0B, a512(100, 20) | 24'hC00000, 1'b0);
    check("R3", "0Bh dummy", int'(dm), 1);
    check("R3", "0Bh valid during pad", int'(dv), 0);
    send(8'hFF);
    check("R3", "0Bh valid after 1 pad", int'(dv), 1);
    check("R3", "0Bh dummy after 1 pad", int'(dm), 0);
    check("R5", "page", int'(page), 100);
    check("R5", "offset", int'(off), 20);
    stop();
  endtask

  task automatic t_legacy_cross();
    start(8'hE8, a528(7, 526), 1'b1);
    check("R3", "E8h dummy", int'(dm), 1);
    repeat (3) send(8'h00);
    check("R3", "E8h still padding", int'(dm), 1);
    send(8'h00);
    check("R3", "E8h valid", int'(dv), 1);
    check("R4", "offset", int'(off), 526);
    send(8'h00);
    check("R7", "offset 527", int'(off), 527);
    send(8'h00);
    check("R8", "next page", int'(page), 8);
    check("R8", "offset 0", int'(off), 0);
    stop();
    check("R11", "valid low", int'(dv), 0);
    check("R11", "dummy low", int'(dm), 0);
  endtask

  task automatic t_array_wrap();
    start(8'h03, a512(8191, 510), 1'b0);
    send(8'h00);
    check("R7", "offset 511", int'(off), 511);
    send(8'h00);
    check("R9", "page wraps", int'(page), 0);
    check("R9", "offset wraps", int'(off), 0);
    stop();
  endtask

  task automatic t_page_read();
    start(8'hD2, a528(9, 527), 1'b1);
    repeat (3) send(8'h00);
    check("R3", "D2h still padding", int'(dm), 1);
    send(8'h00);
    check("R3", "D2h valid", int'(dv), 1);
    send(8'h00);
    check("R10", "528 same page", int'(page), 9);
    check("R10", "528 offset 0", int'(off), 0);
    stop();
    start(8'hD2, a512(3, 511), 1'b0);
    repeat (4) send(8'h00);
    send(8'h00);
    check("R10", "512 same page", int'(page), 3);
    check("R10", "512 offset 0", int'(off), 0);
    stop();
  endtask

  task automatic t_clamp();
    start(8'h03, a528(2, 1000), 1'b1);
    check("R6", "clamped offset", int'(off), 527);
    check("R6", "page", int'(page), 2);
    send(8'h00);
    check("R6", "clamped wraps page", int'(page), 3);
    check("R6", "clamped wraps offset", int'(off), 0);
    stop();
  endtask

  task automatic t_bad_opcode();
    start(8'h84, 24'h000000, 1'b1);
    repeat (4) send(8'h00);
    check("R2", "unknown valid", int'(dv), 0);
    check("R2", "unknown dummy", int'(dm), 0);
    stop();
    start(8'h03, a528(1, 1), 1'b1);
    check("R11", "restart valid", int'(dv), 1);
    check("R11", "restart page", int'(page), 1);
    check("R11", "restart offset", int'(off), 1);
    stop();
  endtask

  task automatic t_abort();
    @(negedge clk); cs_n = 1'b0;
    send(8'h0B); send(8'h12); send(8'h34);
    stop();
    check("R11", "aborted valid", int'(dv), 0);
    check("R11", "aborted dummy", int'(dm), 0);
    start(8'h03, a512(6, 7), 1'b0);
    check("R11", "new cmd page", int'(page), 6);
    check("R11", "new cmd offset", int'(off), 7);
    stop();
  endtask

  task automatic t_mode_latch();
    logic [23:0] a;
    a = a512(4, 5);
    @(negedge clk); cs_n = 1'b0; m528 = 1'b0;
    send(8'h03);
    m528 = 1'b1;
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
    check("R12", "page from 512 split", int'(page), 4);
    check("R12", "offset from 512 split", int'(off), 5);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slow_528();
    t_fast_512();
    t_legacy_cross();
    t_array_wrap();
    t_page_read();
    t_clamp();
    t_bad_opcode();
    t_abort();
    t_mode_latch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule